// File: doc/BRIEF.md
# Bounds Check Trap Unit

This unit evaluates the two range-check operations of a processor's integer pipeline. A request presents a value, a lower bound and an upper bound, an operation mode and an operand size. In single-bound mode the value is tested against zero and an upper limit. In two-bound mode it is tested against an explicit lower and upper limit, and the limits may arrive in reversed order. Before any comparison, every operand is sign-extended from the selected size, so all comparisons are signed full-width comparisons.

One cycle after a request strobe, the unit presents new values for the negative, zero and carry condition flags. A per-flag update mask tells the flag register which of them to write; the others keep their old values. It also presents a trap request that carries the instruction length in bytes that the exception logic must report. The unit does not build exception frames and does not fetch vectors.

Control is a two-state machine. `ST_IDLE` means no result is on the outputs. `ST_REPORT` means a registered result is valid this cycle. Transition `T_ACCEPT` (ST_IDLE to ST_REPORT) and transition `T_CHAIN` (ST_REPORT to ST_REPORT) are both taken on a strobe. Transition `T_DRAIN` (ST_REPORT to ST_IDLE) is taken when there is no strobe. Transition `T_WAIT` (ST_IDLE to ST_IDLE) is taken when there is no strobe.

Top module: `bchk_trap_unit`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle with `req_valid` high. While `res_valid` is low, every flag, mask, trap and length output is 0. All of them are 0 after reset.
- R2: `req_size` selects how all three operands are sign-extended: 0 uses bit 7 as the sign of the low 8 bits, 1 uses bit 15 as the sign of the low 16 bits, and 2 or 3 takes the full 32 bits as a signed value.
- R3: In single-bound mode (`req_mode`=0), `flag_n` is 1 when the value is negative and 0 otherwise. The masks are `upd_n`=1, `upd_c`=1 and `upd_z`=0, and `flag_z` reads 0.
- R4: In single-bound mode with upper bound >= 0, `flag_c` is 1 when value < 0 or value > upper.
- R5: In single-bound mode with upper bound < 0, `flag_c` is 1 only when value > upper and value < 0.
- R6: In single-bound mode, `trap_req` is 1 when value < 0 or value > upper, and `trap_len` is then 2.
- R7: In two-bound mode (`req_mode`=1), `flag_z` is 1 when the value equals either bound. The masks are `upd_z`=1, `upd_c`=1 and `upd_n`=0, and `flag_n` reads 0.
- R8: In two-bound mode with lower <= upper, `flag_c` is 1 when value < lower or value > upper.
- R9: In two-bound mode with lower > upper, `flag_c` is 1 only when value > upper and value < lower.
- R10: In two-bound mode, `trap_req` equals `flag_c`, and `trap_len` is 4 when it traps.
- R11: `trap_len` is 0 whenever `trap_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 1 | 0 = single-bound, 1 = two-bound |
| req_size | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| req_value | input | DATA_W | Value under test |
| req_lower | input | DATA_W | Lower bound (ignored in single-bound mode) |
| req_upper | input | DATA_W | Upper bound |
| res_valid | output | 1 | Result valid |
| flag_n | output | 1 | New negative flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| upd_n | output | 1 | Write enable for N |
| upd_z | output | 1 | Write enable for Z |
| upd_c | output | 1 | Write enable for C |
| trap_req | output | 1 | Bounds trap request |
| trap_len | output | LEN_W | Instruction length in bytes to report |

## Verification
The directed patterns come first. Single-bound cases use a non-negative limit and a negative limit, which separates R4 from R5 and shows where carry and trap disagree. Two-bound cases use ordered limits and reversed limits, and land on each bound and on each side of it, which separates R8 from R9 and exercises the equality flag. Byte and word operands with the sign bit set show that the size code extends every operand and not only the value. Randomized requests then draw values from a small range so that equalities and reversed limits occur often. These requests are mixed with idle and back-to-back strobes to exercise every state transition.

// File: rtl/bchk_pkg.sv
package bchk_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LALT = 2'd3
    } size_e;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_DUAL   = 1'b1
    } mode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } state_e;

    typedef struct packed {
        logic below_lo;
        logic above_hi;
        logic eq_lo;
        logic eq_hi;
        logic val_neg;
        logic hi_neg;
        logic ordered;
    } cmp_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic un;
        logic uz;
        logic uc;
        logic trap;
    } verdict_t;

    localparam int NUM_OPERANDS = 3;

endpackage

// File: rtl/bchk_sext.sv
module bchk_sext
    import bchk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int WORD_W = 16
) (
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] ext
);
    localparam int BYTE_PAD = DATA_W - BYTE_W;
    localparam int WORD_PAD = DATA_W - WORD_W;

    always_comb begin
        unique case (size_e'(size))
            SZ_BYTE: ext = {{BYTE_PAD{raw[BYTE_W-1]}}, raw[BYTE_W-1:0]};
            SZ_WORD: ext = {{WORD_PAD{raw[WORD_W-1]}}, raw[WORD_W-1:0]};
            SZ_LONG: ext = raw;
            SZ_LALT: ext = raw;
            default: ext = raw;
        endcase
    end
endmodule

// File: rtl/bchk_compare.sv
module bchk_compare
    import bchk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] lower,
    input  logic [DATA_W-1:0] upper,
    output cmp_t              cmp
);
    logic signed [DATA_W-1:0] sv, sl, su;

    always_comb begin
        sv = signed'(value);
        sl = signed'(lower);
        su = signed'(upper);
        cmp.below_lo = sv < sl;
        cmp.above_hi = sv > su;
        cmp.eq_lo    = sv == sl;
        cmp.eq_hi    = sv == su;
        cmp.val_neg  = sv[DATA_W-1];
        cmp.hi_neg   = su[DATA_W-1];
        cmp.ordered  = sl <= su;
    end
endmodule

// File: rtl/bchk_decide.sv
module bchk_decide
    import bchk_pkg::*;
#(
    parameter int               LEN_W      = 3,
    parameter logic [LEN_W-1:0] LEN_SINGLE = 3'd2,
    parameter logic [LEN_W-1:0] LEN_DUAL   = 3'd4
) (
    input  logic             mode,
    input  cmp_t             cmp,
    output verdict_t         vd,
    output logic [LEN_W-1:0] len
);
    // In single-bound mode the lower comparison is against zero (muxed upstream).
    logic outside;
    logic inside_wrap;

    always_comb begin
        outside     = cmp.below_lo | cmp.above_hi;
        inside_wrap = cmp.below_lo & cmp.above_hi;
        vd          = '0;
        len         = '0;
        unique case (mode_e'(mode))
            MODE_SINGLE: begin
                vd.n    = cmp.val_neg;
                vd.c    = cmp.hi_neg ? inside_wrap : outside;
                vd.un   = 1'b1;
                vd.uc   = 1'b1;
                vd.trap = cmp.val_neg | cmp.above_hi;
                len     = vd.trap ? LEN_SINGLE : '0;
            end
            MODE_DUAL: begin
                vd.z    = cmp.eq_lo | cmp.eq_hi;
                vd.c    = cmp.ordered ? outside : inside_wrap;
                vd.uz   = 1'b1;
                vd.uc   = 1'b1;
                vd.trap = vd.c;
                len     = vd.trap ? LEN_DUAL : '0;
            end
            default: begin
                vd  = '0;
                len = '0;
            end
        endcase
    end
endmodule

// File: rtl/bchk_trap_unit.sv
module bchk_trap_unit
    import bchk_pkg::*;
#(
    parameter int               DATA_W     = 32,
    parameter int               BYTE_W     = 8,
    parameter int               WORD_W     = 16,
    parameter int               LEN_W      = 3,
    parameter logic [LEN_W-1:0] LEN_SINGLE = 3'd2,
    parameter logic [LEN_W-1:0] LEN_DUAL   = 3'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_mode,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_value,
    input  logic [DATA_W-1:0] req_lower,
    input  logic [DATA_W-1:0] req_upper,
    output logic              res_valid,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              upd_n,
    output logic              upd_z,
    output logic              upd_c,
    output logic              trap_req,
    output logic [LEN_W-1:0]  trap_len
);
    localparam int OP_VAL = 0;
    localparam int OP_LO  = 1;
    localparam int OP_HI  = 2;

    logic [DATA_W-1:0] raw_op [NUM_OPERANDS];
    logic [DATA_W-1:0] ext_op [NUM_OPERANDS];
    logic [DATA_W-1:0] lower_eff;
    cmp_t              cmp;
    verdict_t          vd;
    logic [LEN_W-1:0]  len;
    state_e            state_q, state_d;

    always_comb begin
        raw_op[OP_VAL] = req_value;
        raw_op[OP_LO]  = req_lower;
        raw_op[OP_HI]  = req_upper;
    end

    for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_sext
        bchk_sext #(
            .DATA_W (DATA_W),
            .BYTE_W (BYTE_W),
            .WORD_W (WORD_W)
        ) u_sext (
            .size (req_size),
            .raw  (raw_op[g]),
            .ext  (ext_op[g])
        );
    end

    assign lower_eff = (mode_e'(req_mode) == MODE_SINGLE) ? '0 : ext_op[OP_LO];

    bchk_compare #(.DATA_W(DATA_W)) u_cmp (
        .value (ext_op[OP_VAL]),
        .lower (lower_eff),
        .upper (ext_op[OP_HI]),
        .cmp   (cmp)
    );

    bchk_decide #(
        .LEN_W      (LEN_W),
        .LEN_SINGLE (LEN_SINGLE),
        .LEN_DUAL   (LEN_DUAL)
    ) u_dec (
        .mode (req_mode),
        .cmp  (cmp),
        .vd   (vd),
        .len  (len)
    );

    // Next-state: T_ACCEPT / T_WAIT from idle, T_CHAIN / T_DRAIN from report
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = req_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign res_valid = (state_q == ST_REPORT);

    // Output registers: loaded on a strobe, cleared otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            flag_n   <= 1'b0;
            flag_z   <= 1'b0;
            flag_c   <= 1'b0;
            upd_n    <= 1'b0;
            upd_z    <= 1'b0;
            upd_c    <= 1'b0;
            trap_req <= 1'b0;
            trap_len <= '0;
        end else begin
            flag_n   <= vd.n;
            flag_z   <= vd.z;
            flag_c   <= vd.c;
            upd_n    <= vd.un;
            upd_z    <= vd.uz;
            upd_c    <= vd.uc;
            trap_req <= vd.trap;
            trap_len <= len;
        end
    end
endmodule

// File: rtl/bchk_trap_chk.sv
module bchk_trap_chk #(
    parameter int               LEN_W      = 3,
    parameter logic [LEN_W-1:0] LEN_SINGLE = 3'd2,
    parameter logic [LEN_W-1:0] LEN_DUAL   = 3'd4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_mode,
    input logic             res_valid,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_c,
    input logic             upd_n,
    input logic             upd_z,
    input logic             upd_c,
    input logic             trap_req,
    input logic [LEN_W-1:0] trap_len
);
    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    // R1
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    // R1
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(flag_n | flag_z | flag_c | upd_n | upd_z | upd_c | trap_req));
    // R11
    no_len_without_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> trap_len == '0);
    // R3
    single_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(req_mode)) |-> (upd_n && upd_c && !upd_z && !flag_z));
    // R6
    single_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !$past(req_mode)) |-> trap_len == LEN_SINGLE);
    // R6
    single_carry_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(req_mode) && flag_c) |-> trap_req);
    // R7
    dual_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(req_mode)) |-> (upd_z && upd_c && !upd_n && !flag_n));
    // R10
    dual_trap_is_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(req_mode)) |-> trap_req == flag_c);
    // R10
    dual_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && $past(req_mode)) |-> trap_len == LEN_DUAL);
endmodule

bind bchk_trap_unit bchk_trap_chk #(
    .LEN_W      (LEN_W),
    .LEN_SINGLE (LEN_SINGLE),
    .LEN_DUAL   (LEN_DUAL)
) u_bchk_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .res_valid (res_valid),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .upd_n     (upd_n),
    .upd_z     (upd_z),
    .upd_c     (upd_c),
    .trap_req  (trap_req),
    .trap_len  (trap_len)
);

// File: tb/test_bchk_trap_unit.sv
module test_bchk_trap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_mode = 1'b0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_value = '0, req_lower = '0, req_upper = '0;
    logic        res_valid, flag_n, flag_z, flag_c, upd_n, upd_z, upd_c, trap_req;
    logic [2:0]  trap_len;

    int tests = 0;
    int fails = 0;

    // pending expectation for the next sample
    int    e_valid, e_n, e_z, e_c, e_un, e_uz, e_uc, e_trap, e_len;
    string t_base, t_n, t_z, t_c, t_trap, t_sz;

    always #5 clk = ~clk;

    bchk_trap_unit i_bchk_trap_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_size(req_size), .req_value(req_value), .req_lower(req_lower),
        .req_upper(req_upper), .res_valid(res_valid), .flag_n(flag_n),
        .flag_z(flag_z), .flag_c(flag_c), .upd_n(upd_n), .upd_z(upd_z),
        .upd_c(upd_c), .trap_req(trap_req), .trap_len(trap_len)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic longint sx(input bit [1:0] sz, input logic [31:0] x);
        longint r;
        if (sz == 2'd0) begin
            r = longint'(x[7:0]);
            if (r > 127) r -= 256;
        end else if (sz == 2'd1) begin
            r = longint'(x[15:0]);
            if (r > 32767) r -= 65536;
        end else begin
            r = longint'(x);
            if (r > 64'sd2147483647) r -= 64'sd4294967296;
        end
        return r;
    endfunction

    task automatic compare_all();
        chk(t_base, "res_valid", int'(res_valid), e_valid);
        chk(t_n,    "flag_n",    int'(flag_n),    e_n);
        chk(t_z,    "flag_z",    int'(flag_z),    e_z);
        chk(t_c,    "flag_c",    int'(flag_c),    e_c);
        chk(t_n,    "upd_n",     int'(upd_n),     e_un);
        chk(t_z,    "upd_z",     int'(upd_z),     e_uz);
        chk(t_base, "upd_c",     int'(upd_c),     e_uc);
        chk(t_trap, "trap_req",  int'(trap_req),  e_trap);
        chk({t_trap, "/R11"}, "trap_len", int'(trap_len), e_len);
    endtask

    task automatic step(input bit v, input bit m, input bit [1:0] sz,
                        input logic [31:0] val, input logic [31:0] lo, input logic [31:0] hi);
        longint sv, sl, su;
        @(negedge clk);
        compare_all();
        req_valid = v; req_mode = m; req_size = sz;
        req_value = val; req_lower = lo; req_upper = hi;
        {e_valid, e_n, e_z, e_c, e_un, e_uz, e_uc, e_trap, e_len} = '0;
        t_base = "R1"; t_n = "R1"; t_z = "R1"; t_c = "R1"; t_trap = "R1";
        if (v) begin
            t_sz = (sz == 2'd2 || sz == 2'd3) ? "" : "/R2";
            sv = sx(sz, val); sl = sx(sz, lo); su = sx(sz, hi);
            e_valid = 1;
            e_uc = 1;
            if (!m) begin
                t_n = {"R3", t_sz}; t_z = "R3"; t_trap = {"R6", t_sz};
                e_n = (sv < 0) ? 1 : 0;
                e_un = 1;
                if (su >= 0) begin
                    t_c = {"R4", t_sz};
                    e_c = (sv < 0 || sv > su) ? 1 : 0;
                end else begin
                    t_c = {"R5", t_sz};
                    e_c = (sv > su && sv < 0) ? 1 : 0;
                end
                e_trap = (sv < 0 || sv > su) ? 1 : 0;
                e_len = e_trap ? 2 : 0;
            end else begin
                t_n = "R7"; t_z = {"R7", t_sz}; t_trap = {"R10", t_sz};
                e_z = (sv == sl || sv == su) ? 1 : 0;
                e_uz = 1;
                if (sl <= su) begin
                    t_c = {"R8", t_sz};
                    e_c = (sv < sl || sv > su) ? 1 : 0;
                end else begin
                    t_c = {"R9", t_sz};
                    e_c = (sv > su && sv < sl) ? 1 : 0;
                end
                e_trap = e_c;
                e_len = e_trap ? 4 : 0;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        {e_valid, e_n, e_z, e_c, e_un, e_uz, e_uc, e_trap, e_len} = '0;
        t_base = "R1"; t_n = "R1"; t_z = "R1"; t_c = "R1"; t_trap = "R1"; t_sz = "";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // reset state (R1) is checked by the first step
        step(0, 0, 2, 0, 0, 0);
        // single-bound, non-negative limit (R4, R6)
        step(1, 0, 2, 5, 0, 10);
        step(1, 0, 2, -1, 0, 10);
        step(1, 0, 2, 11, 0, 10);
        step(1, 0, 2, 10, 0, 10);
        step(1, 0, 2, 0, 0, 0);
        step(0, 0, 2, 0, 0, 0);
        // single-bound, negative limit (R5)
        step(1, 0, 2, -3, 0, -5);
        step(1, 0, 2, -7, 0, -5);
        step(1, 0, 2, 3, 0, -5);
        step(1, 0, 2, 32'h8000_0000, 0, 32'h7fff_ffff);
        // size extension (R2)
        step(1, 0, 0, 32'h0000_0080, 0, 32'h0000_007f);
        step(1, 0, 0, 32'h1234_56ff, 0, 32'h0000_0010);
        step(1, 0, 1, 32'h0000_8000, 0, 32'h0000_0100);
        step(1, 1, 0, 32'h0000_0005, 32'h0000_00f0, 32'h0000_0010);
        step(1, 1, 1, 32'h0000_fff0, 32'h0000_0001, 32'h0000_ffe0);
        // two-bound ordered (R8)
        step(1, 1, 2, 2, 2, 8);
        step(1, 1, 2, 8, 2, 8);
        step(1, 1, 2, 1, 2, 8);
        step(1, 1, 2, 9, 2, 8);
        step(1, 1, 2, 5, 2, 8);
        step(1, 1, 2, 3, 3, 3);
        step(1, 1, 2, -10, -10, -2);
        // two-bound reversed (R9)
        step(1, 1, 2, 5, 8, 2);
        step(1, 1, 2, 9, 8, 2);
        step(1, 1, 2, 1, 8, 2);
        step(1, 1, 2, 8, 8, 2);
        step(0, 1, 2, 5, 8, 2);
        // randomized mix with small ranges
        for (int k = 0; k < 600; k++) begin
            step(($urandom % 4) != 0, ($urandom % 2) == 1, 2'($urandom % 4),
                 32'($signed($urandom % 21) - 10) ^ (($urandom % 8 == 0) ? 32'h0000_0080 : 32'h0),
                 32'($signed($urandom % 21) - 10),
                 32'($signed($urandom % 21) - 10));
        end
        step(0, 0, 2, 0, 0, 0);
        step(0, 0, 2, 0, 0, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule